// File: doc/BRIEF.md
# Word Store Merging Buffer

This block sits between the store queue of a load/store unit and a 64-bit external bus. It holds one store at a time. When a qualifying 4-byte store is waiting and the next queued store is a qualifying 4-byte store to the other word of the same doubleword, the two are combined. They leave as a single one-beat 8-byte bus write with all eight byte enables set. Any store that cannot be paired leaves on its own, with byte enables only on the lanes it wrote.

A store qualifies for pairing when all of the following hold:
- It is a naturally aligned word.
- It targets non-guarded space that is cache-inhibited, write-through, or both.
- Its summary "never merge" flag is clear. This flag stands for cacheable, byte-reversed, conditional, external-control, table-walk and floating-point stores.
- The global merge enable is set.

A barrier request carries no data. It closes the current pairing window, so the waiting store goes out alone. A waiting store is also released in three other cases: after a programmable number of idle cycles, when the enable is cleared, or when the next store cannot join it.

Top module: `store_gather_buf`

## Requirements
- R1: A store is a pairing candidate only if `reqSize` is 2 (4 bytes; 0 = 1 byte, 1 = 2 bytes), `reqAddr[1:0]` is 0, `reqGuarded` is 0, at least one of `reqCacheInh` or `reqWriteThru` is 1, and `reqNoMerge` is 0. A non-candidate is issued alone.
- R2: A candidate is waiting and the next store is a candidate in the same doubleword (same `reqAddr[ADDR_W-1:3]`) with the other value of `reqAddr[2]`. The pair is then issued as one write with `busBe` = 8'hFF, `busAddr` = the doubleword address with bits [2:0] zero, and each word in its own lanes.
- R3: Pairing gives the same bus write whichever of the two words arrives first.
- R4: While `gatherEn` is 0, every store is issued alone. Clearing `gatherEn` releases a waiting store.
- R5: Byte lane L is `busData[8L+7:8L]` and `busBe[L]`. For a store of N bytes at offset o = `reqAddr[2:0]`, data is taken right-aligned from `reqData`. In little-endian mode (`bigEndian` = 0) it occupies lanes o to o+N-1. In big-endian mode it occupies lanes 8-o-N to 7-o. A word therefore sits in lanes 4-7 exactly when `reqAddr[2]` XOR `bigEndian` is 1.
- R6: A store with `reqNoMerge` = 1 is never paired, even with a waiting candidate.
- R7: A request with `reqBarrier` = 1 produces no bus write. It releases a waiting store on its own, so that store cannot pair with the next store.
- R8: Two stores to the same word are not paired. They are issued in program order, each as its own write.
- R9: A lone waiting candidate is issued after `IDLE_CYCLES` consecutive cycles with no request.
- R10: A waiting candidate is issued first, alone, when the next store cannot pair with it (for example, a different doubleword).
- R11: While `busValid` is 1 and `busReady` is 0, `busAddr`, `busData` and `busBe` hold steady and `busValid` stays 1. `reqReady` is 0 whenever `busValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gatherEn | input | 1 | Global store-pairing enable |
| bigEndian | input | 1 | Byte order mode, 1 = big-endian |
| reqValid | input | 1 | Store queue offers a request |
| reqReady | output | 1 | Request accepted this cycle |
| reqBarrier | input | 1 | Request is an ordering barrier with no data |
| reqAddr | input | ADDR_W | Byte address of the store |
| reqData | input | 32 | Store data, right-aligned |
| reqSize | input | 2 | Log2 of store size in bytes |
| reqCacheInh | input | 1 | Target is cache-inhibited |
| reqWriteThru | input | 1 | Target is write-through |
| reqGuarded | input | 1 | Target is guarded |
| reqNoMerge | input | 1 | Summary flag: store kind that must never pair |
| busValid | output | 1 | Bus write is offered |
| busReady | input | 1 | Bus accepts the write |
| busAddr | output | ADDR_W | Doubleword-aligned write address |
| busData | output | 64 | Write data by byte lane |
| busBe | output | 8 | Byte enables by lane |

## Verification
The checker relies on two assumptions about the store queue. First, every request is naturally aligned, so a halfword or word never straddles a word boundary. Second, `reqSize` never takes the value 3. Under those two conditions, every write is either confined to one half of the bus or fills all eight lanes. The directed bench only issues bytes at arbitrary offsets and words at multiples of four, and holds each request until it is taken. It changes `busReady` only between clock edges, so the hold-steady property sees a clean stall.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_ISSUE = 2'd2
  } sgbState_e;

  typedef struct packed {
    logic load;   // replace entry with incoming store
    logic merge;  // fold incoming word into entry
  } sgbStrobe_t;
endpackage

// File: rtl/sgb_datapath.sv
module sgb_datapath #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sgb_pkg::sgbStrobe_t strobe,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [1:0]        reqSize,
  output logic              sameDw,
  output logic              sameWord,
  output logic [ADDR_W-1:0] busAddr,
  output logic [63:0]       busData,
  output logic [7:0]        busBe
);
  localparam int DW_LSB = 3;

  logic [ADDR_W-1:0] entAddr;
  logic [63:0]       entData;
  logic [7:0]        entBe;

  logic [3:0]  nBytes;
  logic [3:0]  laneShift;
  logic [7:0]  beRaw;
  logic [31:0] sizeMask;
  logic [63:0] placedData;
  logic [7:0]  placedBe;

  always_comb begin
    nBytes    = 4'd1 << reqSize;
    laneShift = bigEndian ? (4'd8 - {1'b0, reqAddr[2:0]} - nBytes)
                          : {1'b0, reqAddr[2:0]};
    beRaw     = 8'((9'd1 << nBytes) - 9'd1);
    case (reqSize)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
    placedBe   = beRaw << laneShift;
    placedData = {32'd0, reqData & sizeMask} << {laneShift, 3'b000};
  end

  assign sameDw   = (reqAddr[ADDR_W-1:DW_LSB] == entAddr[ADDR_W-1:DW_LSB]);
  assign sameWord = sameDw && (reqAddr[2] == entAddr[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entAddr <= '0;
      entData <= '0;
      entBe   <= '0;
    end else if (strobe.load) begin
      entAddr <= reqAddr;
      entData <= placedData;
      entBe   <= placedBe;
    end else if (strobe.merge) begin
      entData <= entData | placedData;
      entBe   <= entBe | placedBe;
    end
  end

  assign busAddr = {entAddr[ADDR_W-1:DW_LSB], {DW_LSB{1'b0}}};
  assign busData = entData;
  assign busBe   = entBe;
endmodule

// File: rtl/sgb_ctrl.sv
module sgb_ctrl #(
  parameter int IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gatherEn,
  input  logic reqValid,
  input  logic reqBarrier,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqAddrLow,
  input  logic reqCacheInh,
  input  logic reqWriteThru,
  input  logic reqGuarded,
  input  logic reqNoMerge,
  input  logic sameDw,
  input  logic sameWord,
  input  logic busReady,
  output logic reqReady,
  output logic busValid,
  output sgb_pkg::sgbStrobe_t strobe
);
  import sgb_pkg::*;

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);

  sgbState_e state, stateNext;
  logic [CNT_W-1:0] idleCnt;
  logic cand;

  assign cand = (reqSize == 2'd2) && (reqAddrLow == 2'b00) && !reqGuarded &&
                (reqCacheInh || reqWriteThru) && !reqNoMerge && !reqBarrier;

  always_comb begin
    stateNext = state;
    reqReady  = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_EMPTY: begin
        reqReady = 1'b1;
        if (reqValid && !reqBarrier) begin
          strobe.load = 1'b1;
          stateNext   = (cand && gatherEn) ? ST_HOLD : ST_ISSUE;
        end
      end
      ST_HOLD: begin
        if (!gatherEn) begin
          stateNext = ST_ISSUE;
        end else if (reqValid) begin
          stateNext = ST_ISSUE;
          if (reqBarrier) begin
            reqReady = 1'b1;
          end else if (cand && sameDw && !sameWord) begin
            reqReady     = 1'b1;
            strobe.merge = 1'b1;
          end
        end else if (idleCnt == CNT_LAST) begin
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (busReady) stateNext = ST_EMPTY;
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_EMPTY;
      idleCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_HOLD && !reqValid) idleCnt <= idleCnt + 1'b1;
      else                               idleCnt <= '0;
    end
  end

  assign busValid = (state == ST_ISSUE);
endmodule

// File: rtl/store_gather_buf.sv
module store_gather_buf #(
  parameter int ADDR_W      = 32,
  parameter int IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gatherEn,
  input  logic              bigEndian,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqBarrier,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [1:0]        reqSize,
  input  logic              reqCacheInh,
  input  logic              reqWriteThru,
  input  logic              reqGuarded,
  input  logic              reqNoMerge,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [63:0]       busData,
  output logic [7:0]        busBe
);
  sgb_pkg::sgbStrobe_t strobe;
  logic sameDw, sameWord;

  sgb_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gatherEn(gatherEn),
    .reqValid(reqValid), .reqBarrier(reqBarrier), .reqSize(reqSize),
    .reqAddrLow(reqAddr[1:0]), .reqCacheInh(reqCacheInh),
    .reqWriteThru(reqWriteThru), .reqGuarded(reqGuarded),
    .reqNoMerge(reqNoMerge), .sameDw(sameDw), .sameWord(sameWord),
    .busReady(busReady), .reqReady(reqReady), .busValid(busValid),
    .strobe(strobe)
  );

  sgb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .bigEndian(bigEndian),
    .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .sameDw(sameDw), .sameWord(sameWord), .busAddr(busAddr),
    .busData(busData), .busBe(busBe)
  );
endmodule

// File: rtl/sgb_checker.sv
module sgb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqReady,
  input logic              busValid,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [63:0]       busData,
  input logic [7:0]        busBe
);
  // R11: a stalled write keeps its contents
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busData) && $stable(busBe));

  // R11: no request is taken while a write is offered
  a_r11_no_accept_issuing: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> !reqReady);

  // R2: bus addresses are doubleword aligned
  a_r2_dw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> busAddr[2:0] == 3'b000);

  // R5: a write fills one half of the lanes, or all of them when paired
  a_r5_half_or_full: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |-> (busBe != 8'h00) &&
                 (busBe[7:4] == 4'h0 || busBe[3:0] == 4'h0 || busBe == 8'hFF));
endmodule

bind store_gather_buf sgb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .busValid(busValid),
  .busReady(busReady), .busAddr(busAddr), .busData(busData), .busBe(busBe)
);

// File: tb/store_gather_buf_tb.sv
module store_gather_buf_tb;
  localparam int ADDR_W = 32;
  localparam int IDLE   = 4;

  logic clk = 0, rst_n = 0;
  logic gatherEn = 1, bigEndian = 0;
  logic reqValid = 0, reqReady, reqBarrier = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [1:0]  reqSize = 2'd2;
  logic reqCacheInh = 0, reqWriteThru = 0, reqGuarded = 0, reqNoMerge = 0;
  logic busValid, busReady = 1;
  logic [ADDR_W-1:0] busAddr;
  logic [63:0] busData;
  logic [7:0]  busBe;

  int checks = 0, errors = 0;
  logic [ADDR_W-1:0] logAddr [64];
  logic [63:0]       logData [64];
  logic [7:0]        logBe   [64];
  int logCnt = 0;

  always #2 clk = ~clk;

  store_gather_buf #(.ADDR_W(ADDR_W), .IDLE_CYCLES(IDLE)) u_dut (.*);

  always @(posedge clk) begin
    if (rst_n && busValid && busReady) begin
      logAddr[logCnt] <= busAddr;
      logData[logCnt] <= busData;
      logBe[logCnt]   <= busBe;
      logCnt          <= logCnt + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendRaw(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         input logic [1:0] sz, input logic ci, input logic wt,
                         input logic gd, input logic nm, input logic bar);
    reqValid = 1; reqAddr = a; reqData = d; reqSize = sz;
    reqCacheInh = ci; reqWriteThru = wt; reqGuarded = gd; reqNoMerge = nm;
    reqBarrier = bar;
    forever begin
      #1;
      if (reqReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 0; reqBarrier = 0;
  endtask

  task automatic storeWord(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    sendRaw(a, d, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    repeat (IDLE + 6) @(negedge clk);
  endtask

  task automatic checkWrite(input string req, input int idx, input logic [ADDR_W-1:0] a,
                            input logic [63:0] d, input logic [7:0] be);
    check({req, " addr"}, 64'(logAddr[idx]), 64'(a));
    check({req, " data"}, logData[idx], d);
    check({req, " be"},   64'(logBe[idx]), 64'(be));
  endtask

  task automatic tReset();
    check("R11 reset busValid", 64'(busValid), 64'd0);
    check("R11 reset reqReady", 64'(reqReady), 64'd1);
  endtask

  task automatic tMergeLe();  // R2
    int base = logCnt;
    bigEndian = 0;
    storeWord(32'h100, 32'hAAAA_0001);
    storeWord(32'h104, 32'hBBBB_0002);
    drain();
    check("R2 one write", 64'(logCnt - base), 64'd1);
    checkWrite("R2 merged LE", base, 32'h100, 64'hBBBB_0002_AAAA_0001, 8'hFF);
  endtask

  task automatic tMergeReverse();  // R3
    int base = logCnt;
    storeWord(32'h10C, 32'hBBBB_0002);
    storeWord(32'h108, 32'hAAAA_0001);
    drain();
    check("R3 one write", 64'(logCnt - base), 64'd1);
    checkWrite("R3 reverse order", base, 32'h108, 64'hBBBB_0002_AAAA_0001, 8'hFF);
  endtask

  task automatic tMergeBe();  // R5 big-endian pairing
    int base = logCnt;
    bigEndian = 1;
    storeWord(32'h200, 32'h1111_2222);
    sendRaw(32'h204, 32'h3333_4444, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    drain();
    bigEndian = 0;
    check("R5 BE one write", 64'(logCnt - base), 64'd1);
    checkWrite("R5 BE lanes", base, 32'h200, 64'h1111_2222_3333_4444, 8'hFF);
  endtask

  task automatic tDisabled();  // R4
    int base = logCnt;
    gatherEn = 0;
    storeWord(32'h300, 32'hA);
    storeWord(32'h304, 32'hB);
    drain();
    gatherEn = 1;
    check("R4 two writes", 64'(logCnt - base), 64'd2);
    checkWrite("R4 first", base, 32'h300, 64'hA, 8'h0F);
    checkWrite("R4 second", base + 1, 32'h300, 64'hB << 32, 8'hF0);
  endtask

  task automatic tIneligible();  // R6, R1
    int base = logCnt;
    storeWord(32'h400, 32'hC);
    sendRaw(32'h404, 32'hD, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    drain();
    check("R6 no pairing", 64'(logCnt - base), 64'd2);
    checkWrite("R6 second alone", base + 1, 32'h400, 64'hD << 32, 8'hF0);
    base = logCnt;
    sendRaw(32'h410, 32'hE, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    storeWord(32'h414, 32'hF);
    drain();
    check("R1 guarded not paired", 64'(logCnt - base), 64'd2);
    base = logCnt;
    sendRaw(32'h420, 32'h5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    storeWord(32'h424, 32'h6);
    drain();
    check("R1 cacheable not paired", 64'(logCnt - base), 64'd2);
  endtask

  task automatic tBarrier();  // R7
    int base = logCnt;
    storeWord(32'h500, 32'h1);
    sendRaw(32'h0, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    storeWord(32'h504, 32'h2);
    drain();
    check("R7 barrier splits", 64'(logCnt - base), 64'd2);
    checkWrite("R7 first alone", base, 32'h500, 64'h1, 8'h0F);
  endtask

  task automatic tSameWord();  // R8
    int base = logCnt;
    storeWord(32'h600, 32'h11);
    storeWord(32'h600, 32'h22);
    drain();
    check("R8 two writes", 64'(logCnt - base), 64'd2);
    checkWrite("R8 older first", base, 32'h600, 64'h11, 8'h0F);
    checkWrite("R8 newer second", base + 1, 32'h600, 64'h22, 8'h0F);
  endtask

  task automatic tIdle();  // R9
    storeWord(32'h700, 32'h77);
    repeat (IDLE - 1) @(negedge clk);
    check("R9 still waiting", 64'(busValid), 64'd0);
    @(negedge clk);
    check("R9 released after idle", 64'(busValid), 64'd1);
    drain();
  endtask

  task automatic tOtherDw();  // R10
    int base = logCnt;
    storeWord(32'h800, 32'h1);
    storeWord(32'h908, 32'h2);
    drain();
    check("R10 two writes", 64'(logCnt - base), 64'd2);
    checkWrite("R10 first", base, 32'h800, 64'h1, 8'h0F);
    checkWrite("R10 second", base + 1, 32'h908, 64'h2, 8'h0F);
  endtask

  task automatic tStall();  // R11
    int base = logCnt;
    busReady = 0;
    sendRaw(32'hA04, 32'hDEAD_BEEF, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R11 offered", 64'(busValid), 64'd1);
    repeat (3) @(negedge clk);
    check("R11 held valid", 64'(busValid), 64'd1);
    check("R11 held data", busData, 64'hDEAD_BEEF_0000_0000);
    check("R11 no accept", 64'(reqReady), 64'd0);
    busReady = 1;
    drain();
    check("R11 one write", 64'(logCnt - base), 64'd1);
  endtask

  task automatic tSubword();  // R5
    int base = logCnt;
    sendRaw(32'hB05, 32'hAB, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    bigEndian = 1;
    drain();
    sendRaw(32'hB05, 32'hCD, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drain();
    bigEndian = 0;
    checkWrite("R5 LE byte", base, 32'hB00, 64'hAB << 40, 8'h20);
    checkWrite("R5 BE byte", base + 1, 32'hB00, 64'hCD << 16, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tReset();
    tMergeLe();
    tMergeReverse();
    tMergeBe();
    tDisabled();
    tIneligible();
    tBarrier();
    tSameWord();
    tIdle();
    tOtherDw();
    tStall();
    tSubword();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule